// File: doc/BRIEF.md
# GPIO Pin Bank Register Controller

This block is a register bank that controls 94 general-purpose pins through a single-cycle 32-bit register port with byte addresses. Software uses it to claim pins for GPIO use, set each pin's direction and output level, read back synchronized pad input levels, and manage per-pin event status and enable bits. The block drives the pad output value and output enable, and captures pad input levels.

State comes in three forms. Bank-wide bitmap words each cover 32 pins: firmware ownership, event status and event enable. Each pin has two 32-bit configuration words. One global control word holds software-defined settings. A separate detector block supplies per-pin event pulses. This bank latches those pulses as status only for pins whose input sensing is on, and it raises one combined interrupt line.

A firmware-lock input freezes the ownership bitmap. A pin whose ownership bit is 0 is reserved for firmware and never gets its output driver enabled.

Top module: `pinbank_ctrl`

## Requirements
- R1: Pin n sits at bit n%32 of bitmap word n/32. The ownership words are at 0x00/0x04/0x08, the status words at 0x80/0x84/0x88 and the enable words at 0x90/0x94/0x98. The global control word is at 0x7C and reads back all 32 bits written to it.
- R2: Configuration word A of pin p is at 0x100+8p and word B is at 0x104+8p. Word A: bit 31 is the output level, bit 30 is the read-only input level, bit 2 is the direction (1 = input, 0 = output) and bit 0 is the use select (1 = GPIO, 0 = native). Word B: bit 2 is sense-disable and bits 1:0 are the pull select. All other bits read 0.
- R3: pad_oe[p] is 1 only when the pin is owned, its use select is 1 and its direction is 0. pad_out[p] follows the output level. Both are registered and change on the clock edge after the register write.
- R4: Each pad input passes through a two-flop synchronizer before it reaches the input level bit. The input level bit reads 0 while sense-disable is 1.
- R5: A pulse on evt_in[p] sets status bit p only while the pin's sense-disable is 0. Writing 1 to a status bit clears it, writing 0 leaves it unchanged, and a new event in the same cycle as a clear wins.
- R6: irq_out is 1 on the edge after any pin has both its status bit and its enable bit set, and it returns to 0 on the edge after no such pin remains.
- R7: Writes to the ownership words are ignored while fw_lock is 1. Clearing a pin's ownership bit removes its output enable.
- R8: Reads of unmapped or misaligned addresses return 0 and writes to them change nothing. This includes 0x3F0 and above, gaps between regions, and bitmap bits for pins 94 and 95.
- R9: After reset every pin is an input (direction 1) with sense-disable 1, use select 0, output level 0 and pull 0. The ownership bitmap is all ones, the status, enable and control words are 0, and pad_oe, irq_out and rdata are 0.
- R10: rdata is registered. It shows the addressed word on the edge where rd_en is sampled high and holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_lock | input | 1 | Freezes the ownership bitmap while high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | 94 | Pad input levels (asynchronous) |
| pad_out | output | 94 | Pad output values |
| pad_oe | output | 94 | Pad output enables |
| evt_in | input | 94 | Per-pin event pulses from the detector |
| irq_out | output | 1 | Combined enabled-status interrupt |

## Verification
On every cycle, the assertions check four things: no output enable is raised for a pin configured as an input, no status bit rises for a pin whose sensing is off, irq_out never rises without an enabled pending status, and the ownership bitmap stays stable under a locked write. They also check that reads at high unmapped addresses return zero, that read data holds between reads and that reset leaves the outputs quiet. Other behaviours can only be shown by the bench scenarios. These are the exact field positions in the configuration words, the two-cycle synchronizer latency, the clear-versus-set race on status bits, the masking of bits for pins 94 and 95, and write-ignore on misaligned addresses.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  // region byte offsets
  localparam int OWN_OFS    = 'h000;
  localparam int GCTL_OFS   = 'h07C;
  localparam int STAT_OFS   = 'h080;
  localparam int EN_OFS     = 'h090;
  localparam int CFG_OFS    = 'h100;
  localparam int CFG_STRIDE = 8;
  localparam int WORD_BYTES = 4;
  localparam int BITS_PER_WORD = 32;

  // configuration word A bit positions
  localparam int CA_OUT = 31;
  localparam int CA_IN  = 30;
  localparam int CA_DIR = 2;
  localparam int CA_USE = 0;
  // configuration word B bit positions
  localparam int CB_SDIS = 2;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_OWN,
    RG_GCTL,
    RG_STAT,
    RG_EN,
    RG_CFGA,
    RG_CFGB
  } region_e;

endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 94,
  parameter int ADDR_W   = 12,
  parameter int PIN_W    = 7,
  parameter int WORD_W   = 2,
  parameter int NWORDS   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [PIN_W-1:0]  pin_idx,
  output logic [WORD_W-1:0] word_idx
);

  localparam logic [ADDR_W-1:0] CFG_LO  = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] CFG_HI  = ADDR_W'(CFG_OFS + NUM_PINS * CFG_STRIDE);
  localparam logic [ADDR_W-1:0] OWN_LO  = ADDR_W'(OWN_OFS);
  localparam logic [ADDR_W-1:0] OWN_HI  = ADDR_W'(OWN_OFS + NWORDS * WORD_BYTES);
  localparam logic [ADDR_W-1:0] STAT_LO = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] STAT_HI = ADDR_W'(STAT_OFS + NWORDS * WORD_BYTES);
  localparam logic [ADDR_W-1:0] EN_LO   = ADDR_W'(EN_OFS);
  localparam logic [ADDR_W-1:0] EN_HI   = ADDR_W'(EN_OFS + NWORDS * WORD_BYTES);
  localparam logic [ADDR_W-1:0] GCTL_A  = ADDR_W'(GCTL_OFS);

  logic [ADDR_W-1:0] cfg_off, own_off, stat_off, en_off;
  logic              aligned;

  assign cfg_off  = addr - CFG_LO;
  assign own_off  = addr - OWN_LO;
  assign stat_off = addr - STAT_LO;
  assign en_off   = addr - EN_LO;
  assign aligned  = (addr[1:0] == 2'b00);

  always_comb begin
    region   = RG_NONE;
    pin_idx  = PIN_W'(cfg_off >> 3);
    word_idx = '0;
    if (aligned) begin
      if (addr >= CFG_LO && addr < CFG_HI) begin
        region = addr[2] ? RG_CFGB : RG_CFGA;
      end else if (addr == GCTL_A) begin
        region = RG_GCTL;
      end else if (addr >= OWN_LO && addr < OWN_HI) begin
        region   = RG_OWN;
        word_idx = WORD_W'(own_off >> 2);
      end else if (addr >= STAT_LO && addr < STAT_HI) begin
        region   = RG_STAT;
        word_idx = WORD_W'(stat_off >> 2);
      end else if (addr >= EN_LO && addr < EN_HI) begin
        region   = RG_EN;
        word_idx = WORD_W'(en_off >> 2);
      end
    end
  end

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int WIDTH  = 94,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pinbank_pin_cfg.sv
module pinbank_pin_cfg #(
  parameter int NUM_PINS = 94,
  parameter int PIN_W    = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_a,
  input  logic                wr_b,
  input  logic [PIN_W-1:0]    pin_idx,
  input  logic                wd_out,
  input  logic                wd_dir,
  input  logic                wd_use,
  input  logic                wd_sdis,
  input  logic [1:0]          wd_pull,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] use_q,
  output logic [NUM_PINS-1:0] sdis_q,
  output logic [1:0]          pull_q [NUM_PINS]
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit;
    assign hit = (pin_idx == PIN_W'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[p] <= 1'b0;
        dir_q[p] <= 1'b1;
        use_q[p] <= 1'b0;
      end else if (wr_a && hit) begin
        out_q[p] <= wd_out;
        dir_q[p] <= wd_dir;
        use_q[p] <= wd_use;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        sdis_q[p] <= 1'b1;
        pull_q[p] <= 2'b00;
      end else if (wr_b && hit) begin
        sdis_q[p] <= wd_sdis;
        pull_q[p] <= wd_pull;
      end
    end
  end

endmodule

// File: rtl/pinbank_bitmaps.sv
module pinbank_bitmaps #(
  parameter int NUM_PINS = 94,
  parameter int WORD_W   = 2,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fw_lock,
  input  logic                wr_own,
  input  logic                wr_stat,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   word_idx,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] evt_set,
  output logic [NUM_PINS-1:0] own_q,
  output logic [NUM_PINS-1:0] stat_q,
  output logic [NUM_PINS-1:0] en_q
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_bit
    localparam int WI = p / DATA_W;
    localparam int BI = p % DATA_W;
    logic sel;
    assign sel = (word_idx == WORD_W'(WI));

    always_ff @(posedge clk) begin
      if (rst)                           own_q[p] <= 1'b1;
      else if (wr_own && sel && !fw_lock) own_q[p] <= wdata[BI];
    end

    always_ff @(posedge clk) begin
      if (rst)                              stat_q[p] <= 1'b0;
      else if (evt_set[p])                  stat_q[p] <= 1'b1;
      else if (wr_stat && sel && wdata[BI]) stat_q[p] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst)               en_q[p] <= 1'b0;
      else if (wr_en && sel) en_q[p] <= wdata[BI];
    end
  end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 94,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fw_lock,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] evt_in,
  output logic                irq_out
);

  localparam int NWORDS = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int PADW   = NWORDS * DATA_W;
  localparam int WORD_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  region_e           region;
  logic [PIN_W-1:0]  pin_idx;
  logic [WORD_W-1:0] word_idx;

  logic [NUM_PINS-1:0] out_q, dir_q, use_q, sdis_q;
  logic [1:0]          pull_q [NUM_PINS];
  logic [NUM_PINS-1:0] own_q, stat_q, en_q;
  logic [NUM_PINS-1:0] sync_in, in_lvl, evt_gated;
  logic [DATA_W-1:0]   gctl_q;
  logic [DATA_W-1:0]   rd_mux;
  logic [PADW-1:0]     own_w, stat_w, en_w;

  pinbank_decode #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .PIN_W(PIN_W),
    .WORD_W(WORD_W), .NWORDS(NWORDS)
  ) u_dec (
    .addr(addr), .region(region), .pin_idx(pin_idx), .word_idx(word_idx)
  );

  pinbank_pin_cfg #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_a(wr_en && region == RG_CFGA),
    .wr_b(wr_en && region == RG_CFGB),
    .pin_idx(pin_idx),
    .wd_out(wdata[CA_OUT]), .wd_dir(wdata[CA_DIR]), .wd_use(wdata[CA_USE]),
    .wd_sdis(wdata[CB_SDIS]), .wd_pull(wdata[1:0]),
    .out_q(out_q), .dir_q(dir_q), .use_q(use_q), .sdis_q(sdis_q),
    .pull_q(pull_q)
  );

  pinbank_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_in)
  );

  // sensing gate: a disabled pin reads low and raises no events
  assign in_lvl    = sync_in & ~sdis_q;
  assign evt_gated = evt_in & ~sdis_q;

  pinbank_bitmaps #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_bmp (
    .clk(clk), .rst(rst), .fw_lock(fw_lock),
    .wr_own(wr_en && region == RG_OWN),
    .wr_stat(wr_en && region == RG_STAT),
    .wr_en(wr_en && region == RG_EN),
    .word_idx(word_idx), .wdata(wdata), .evt_set(evt_gated),
    .own_q(own_q), .stat_q(stat_q), .en_q(en_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                              gctl_q <= '0;
    else if (wr_en && region == RG_GCTL)  gctl_q <= wdata;
  end

  // zero-extended bitmaps so the bits past the last pin read 0
  assign own_w  = PADW'(own_q);
  assign stat_w = PADW'(stat_q);
  assign en_w   = PADW'(en_q);

  always_comb begin
    rd_mux = '0;
    unique case (region)
      RG_OWN:  rd_mux = own_w[word_idx*DATA_W +: DATA_W];
      RG_STAT: rd_mux = stat_w[word_idx*DATA_W +: DATA_W];
      RG_EN:   rd_mux = en_w[word_idx*DATA_W +: DATA_W];
      RG_GCTL: rd_mux = gctl_q;
      RG_CFGA: begin
        rd_mux[CA_OUT] = out_q[pin_idx];
        rd_mux[CA_IN]  = in_lvl[pin_idx];
        rd_mux[CA_DIR] = dir_q[pin_idx];
        rd_mux[CA_USE] = use_q[pin_idx];
      end
      RG_CFGB: begin
        rd_mux[CB_SDIS] = sdis_q[pin_idx];
        rd_mux[1:0]     = pull_q[pin_idx];
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      pad_out <= '0;
      pad_oe  <= '0;
      irq_out <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      pad_out <= out_q;
      pad_oe  <= own_q & use_q & ~dir_q;
      irq_out <= |(stat_q & en_q);
    end
  end

endmodule

// File: rtl/pinbank_checker.sv
module pinbank_checker #(
  parameter int NUM_PINS = 94,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                fw_lock,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   rdata,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                irq_out,
  input logic [NUM_PINS-1:0] own_q,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] sdis_q,
  input logic [NUM_PINS-1:0] stat_q,
  input logic [NUM_PINS-1:0] en_q
);

  // R3: an input-direction pin never has its driver enabled
  a_r3_no_oe_on_input: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & $past(dir_q)) == '0));

  // R5: a pin with sensing off never gains a status bit
  a_r5_sense_gate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & $past(sdis_q)) == '0));

  // R6: the interrupt line needs an enabled pending status
  a_r6_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(|(stat_q & en_q)));

  // R7: locked writes leave the ownership bitmap untouched
  a_r7_lock_hold: assert property (@(posedge clk) disable iff (rst)
    (fw_lock && wr_en) |=> $stable(own_q));

  // R8: high unmapped addresses read as zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= ADDR_W'('h3F0)) |=> (rdata == '0));

  // R9: reset leaves outputs quiet and all pins owned
  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && !irq_out && own_q == '1 && rdata == '0));

  // R10: read data holds while no read is requested
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !$past(rst)) |=> $stable(rdata));

endmodule

bind pinbank_ctrl pinbank_checker #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .fw_lock(fw_lock), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .rdata(rdata), .pad_oe(pad_oe), .irq_out(irq_out),
  .own_q(own_q), .dir_q(dir_q), .sdis_q(sdis_q), .stat_q(stat_q), .en_q(en_q)
);

// File: tb/pinbank_ctrl_bench.sv
module pinbank_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 94;
  localparam int NV = 11;

  // table: write addr/data, then read back the same addr and expect value
  // 0:R1 gctl  1-4:R2 cfg fields  5:R8 pins 94/95  6,7,9:R8 unmapped/misaligned
  // 8:R5 W1C of zero status  10:R1/R7 ownership word 1 unlocked
  localparam logic [11:0] T_ADDR [NV] = '{
    12'h07C, 12'h100, 12'h104, 12'h3E8, 12'h3EC, 12'h098,
    12'h3F0, 12'h040, 12'h084, 12'h101, 12'h004 };
  localparam logic [31:0] T_WD [NV] = '{
    32'hA5A5_1234, 32'h8000_0005, 32'h0000_0003, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'h0000_FFFF };
  localparam logic [31:0] T_EXP [NV] = '{
    32'hA5A5_1234, 32'h8000_0005, 32'h0000_0003, 32'h8000_0005, 32'h0000_0007,
    32'h3FFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
    32'h0000_FFFF };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fw_lock = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [NP-1:0] evt_in = '0;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinbank_ctrl u_pinbank_ctrl (
    .clk(clk), .rst(rst), .fw_lock(fw_lock), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .evt_in(evt_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    chk("R9 rdata after reset", rdata, 32'h0);
    chk("R9 pad_oe after reset", 32'(pad_oe != '0), 32'h0);
    chk("R9 irq_out after reset", 32'(irq_out), 32'h0);
    rd(12'h000, v); chk("R9 ownership word0 reset", v, 32'hFFFF_FFFF);
    rd(12'h128, v); chk("R9 pin5 cfg A reset", v, 32'h0000_0004);
    rd(12'h12C, v); chk("R9 pin5 cfg B reset", v, 32'h0000_0004);
    rd(12'h090, v); chk("R9 enable word0 reset", v, 32'h0);

    // table walk (R1 R2 R5 R7 R8)
    for (int i = 0; i < NV; i++) begin
      wr(T_ADDR[i], T_WD[i]);
      rd(T_ADDR[i], v);
      chk($sformatf("R1/R2/R8 table[%0d]", i), v, T_EXP[i]);
    end

    // R10 hold: rdata unchanged with rd_en low while state changes
    wr(12'h07C, 32'h1111_2222);
    chk("R10 rdata holds without read", rdata, 32'h0000_FFFF);

    // R3 output drive on pin 3
    wr(12'h118, 32'h8000_0001); settle();
    chk("R3 pin3 oe when GPIO output", 32'(pad_oe[3]), 32'h1);
    chk("R3 pin3 output level high", 32'(pad_out[3]), 32'h1);
    wr(12'h118, 32'h0000_0001); settle();
    chk("R3 pin3 output level low", 32'(pad_out[3]), 32'h0);
    wr(12'h118, 32'h0000_0005); settle();
    chk("R3 pin3 no oe as input", 32'(pad_oe[3]), 32'h0);
    wr(12'h118, 32'h8000_0000); settle();
    chk("R3 pin3 no oe in native use", 32'(pad_oe[3]), 32'h0);

    // R7 ownership gating and lock
    wr(12'h118, 32'h8000_0001); settle();
    wr(12'h000, 32'hFFFF_FFF7); settle();
    chk("R7 unowned pin3 loses oe", 32'(pad_oe[3]), 32'h0);
    fw_lock = 1'b1;
    wr(12'h000, 32'h0000_0000);
    rd(12'h000, v); chk("R7 locked ownership write ignored", v, 32'hFFFF_FFF7);
    fw_lock = 1'b0;

    // R4 input sampling
    pad_in[0] = 1'b1; settle(); settle();
    rd(12'h100, v); chk("R4 pin0 input level seen", v, 32'hC000_0005);
    pad_in[1] = 1'b1; settle(); settle();
    rd(12'h108, v); chk("R4 pin1 sensing off reads 0", v, 32'h0000_0004);
    wr(12'h114, 32'h0000_0000);
    @(negedge clk);
    pad_in[2] = 1'b1; rd_en = 1'b1; addr = 12'h110;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R4 pin2 not visible before sync", rdata, 32'h0000_0004);
    settle();
    rd(12'h110, v); chk("R4 pin2 visible after sync", v, 32'h4000_0004);

    // R5 status capture
    @(negedge clk); evt_in[1] = 1'b1; @(negedge clk); evt_in[1] = 1'b0;
    rd(12'h080, v); chk("R5 event ignored with sensing off", v, 32'h0);
    @(negedge clk); evt_in[0] = 1'b1; @(negedge clk); evt_in[0] = 1'b0;
    rd(12'h080, v); chk("R5 event sets status", v, 32'h0000_0001);
    settle();
    chk("R6 irq low while enable clear", 32'(irq_out), 32'h0);

    // R6 combined interrupt
    wr(12'h090, 32'h0000_0001); settle();
    chk("R6 irq with enabled status", 32'(irq_out), 32'h1);
    wr(12'h080, 32'h0000_0001);
    rd(12'h080, v); chk("R5 W1C clears status", v, 32'h0);
    settle();
    chk("R6 irq drops after clear", 32'(irq_out), 32'h0);

    // R5 set wins over simultaneous clear
    @(negedge clk); evt_in[0] = 1'b1; @(negedge clk);
    wr_en = 1'b1; addr = 12'h080; wdata = 32'h0000_0001;
    @(negedge clk);
    wr_en = 1'b0; evt_in[0] = 1'b0;
    rd(12'h080, v); chk("R5 event wins over clear", v, 32'h0000_0001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule